// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM With Zero Turnaround

This block is a synthesizable behavioural model of a small synchronous SRAM. Reads are flow-through and writes need no bus turnaround cycle. One clock edge registers a command, an address and a byte mask. A read then returns data from the registered address combinationally, in the cycle that follows that edge. A write takes its data on the next clock edge. Back-to-back reads and writes can therefore share the data bus with no idle cycles between them.

One control input picks between two actions. When it is low, a new access starts from the external address. When it is high, the current access continues at the next address of a four-word burst. Three chip selects, a clock enable, a sleep input and an asynchronous output enable control when the block drives the bus and when it takes any action. The tri-state bus is split into an input word, an output word and a drive-enable flag, so the bus is driven only when the drive-enable flag is high.

Top module: `nbl_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge) the block is deselected and `q_drive` is 0 whatever `oe_n` is.
- R2: A load edge (`adv_ld`=0) selects the block only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination starts a deselect, which drives no data and writes no memory.
- R3: A selected load with `we_n`=1 starts a read. From the next cycle, while `oe_n`=0, `q` shows the word at the loaded address and `q_drive` is 1.
- R4: An edge with `adv_ld`=1 keeps the current operation and adds one, modulo 4, to address bits [1:0]. The upper address bits stay unchanged. The chip selects and `we_n` are ignored on such an edge.
- R5: A selected load with `we_n`=0 starts a write. On the following active edge, `din` is stored at the registered address. Byte i (bits 8i+7:8i) is stored only when `bw_n[i]` was 0 at the load edge.
- R6: A write load with `we_n`=0 and every `bw_n` bit at 1 is a write abort. It changes no memory byte on the load edge or on any continuing edge, but its burst address still advances.
- R7: During any write cycle, full or partial, `q_drive` is 0 whatever `oe_n` is.
- R8: `oe_n` is not sampled by the clock. It removes or restores the drive of read data within the same cycle, with no edge.
- R9: An edge with `cke_n`=1 is ignored. The address, the operation and the byte mask keep their values, and no memory write happens.
- R10: While `sleep`=1, `q_drive` is 0 and all clock edges are ignored. When sleep ends, the operation in progress before sleep resumes.
- R11: A continuing edge after a deselect stays deselected, so no data is driven.
- R12: A dummy read (a read with `oe_n`=1) still advances the burst address on continuing edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load a new access, 1 = continue the burst |
| we_n | input | 1 | Write enable, active low, sampled on load edges |
| bw_n | input | NB | Per-byte write selects, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| sleep | input | 1 | Sleep mode, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | External word address |
| din | input | 8*NB | Write data, taken one edge after the write load |
| q | output | 8*NB | Read data, zero when not driven |
| q_drive | output | 1 | High when the block drives the data bus |

## Verification
A wrong operation register soon shows on `q_drive`. A bad decode of a read or a write makes the bus drive during a write, or stay silent during a read, within one cycle of the edge. A burst counter that is out of step, or a stall that lets the counter move, gives a wrong word on `q` at the next read beat. A lost write byte or a stray write shows up only when that address is read again. For that reason the bench reads back every address it has written, or tried to write, through a fresh load.

// File: rtl/nbl_pkg.sv
// Shared types for the flow-through SRAM model.
package nbl_pkg;
    // Operation held between edges.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } nbl_op_e;
endpackage

// File: rtl/nbl_ctrl.sv
// Command decoder and address/burst register.
// Registers the operation, the address and the byte mask on each active edge.
// An active edge is one with the clock enabled and the block awake.
// Assumes AW is greater than BURST_BITS.
module nbl_ctrl
    import nbl_pkg::*;
#(
    parameter int AW         = 4,
    parameter int NB         = 2,
    parameter int BURST_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          adv_ld,
    input  logic          we_n,
    input  logic [NB-1:0] bw_n,
    input  logic          cke_n,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    output nbl_op_e       op_q,
    output logic [AW-1:0] addr_q,
    output logic [NB-1:0] mask_q,
    output logic          wr_fire
);
    localparam int UPPER = AW - BURST_BITS;

    logic          edge_en;
    logic          selected;
    logic [AW-1:0] addr_next;

    // An edge counts only when the clock is enabled and the block is awake.
    assign edge_en  = !cke_n && !sleep;
    assign selected = !cs1_n && cs2 && !cs3_n;
    // Store the write data of the previous write edge on this active edge.
    assign wr_fire  = edge_en && (op_q == OP_WRITE);

    // Advance only the low burst bits; the upper bits pass through unchanged.
    always_comb begin
        addr_next = addr_q;
        addr_next[BURST_BITS-1:0] = addr_q[BURST_BITS-1:0] + 1'b1;
    end

    // Register the operation, the address and the byte mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            mask_q <= '0;
        end else if (edge_en) begin
            if (!adv_ld) begin
                addr_q <= addr;
                if (!selected) begin
                    op_q   <= OP_IDLE;
                    mask_q <= '0;
                end else if (we_n) begin
                    op_q   <= OP_READ;
                    mask_q <= '0;
                end else begin
                    op_q   <= OP_WRITE;
                    mask_q <= ~bw_n;
                end
            end else begin
                addr_q <= addr_next;
            end
        end
    end

    // The upper width is used only to state the assumption about AW.
    logic unused_upper;
    assign unused_upper = (UPPER > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/nbl_array.sv
// Byte-writable storage array.
// Read is combinational from the read address; a write updates the enabled
// bytes at the write address on the rising edge. Contents are not reset.
module nbl_array #(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [NB-1:0]   wr_mask,
    input  logic [AW-1:0]   wr_addr,
    input  logic [8*NB-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [8*NB-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = 8 * NB;

    logic [DW-1:0] mem [DEPTH];

    // Write each enabled byte lane.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_mask[b]) mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    // Flow-through read.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nbl_outdrv.sv
// Output-bus gating.
// Drives read data only for a read with the output enable active and the block
// awake. Writes, idle cycles and sleep leave the bus released.
module nbl_outdrv
    import nbl_pkg::*;
#(
    parameter int DW = 16
) (
    input  nbl_op_e         op,
    input  logic            oe_n,
    input  logic            sleep,
    input  logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   q,
    output logic            q_drive
);
    // Combinational drive decision; oe_n is not registered.
    always_comb begin
        q_drive = (op == OP_READ) && !oe_n && !sleep;
        q       = q_drive ? rd_data : '0;
    end
endmodule

// File: rtl/nbl_sram.sv
// Top of the flow-through SRAM model.
// Connects the decoder, the array and the output gating.
// The tri-state bus is modelled as a separate input word, output word and
// drive flag.
module nbl_sram
    import nbl_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs1_n,
    input  logic            cs2,
    input  logic            cs3_n,
    input  logic            adv_ld,
    input  logic            we_n,
    input  logic [NB-1:0]   bw_n,
    input  logic            cke_n,
    input  logic            sleep,
    input  logic            oe_n,
    input  logic [AW-1:0]   addr,
    input  logic [8*NB-1:0] din,
    output logic [8*NB-1:0] q,
    output logic            q_drive
);
    localparam int DW = 8 * NB;

    nbl_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [NB-1:0] mask_q;
    logic          wr_fire;
    logic [DW-1:0] rd_data;

    nbl_ctrl #(.AW(AW), .NB(NB), .BURST_BITS(2)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .cke_n(cke_n),
        .sleep(sleep), .addr(addr), .op_q(op_q), .addr_q(addr_q),
        .mask_q(mask_q), .wr_fire(wr_fire)
    );

    nbl_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .wr_en(wr_fire), .wr_mask(mask_q), .wr_addr(addr_q),
        .wr_data(din), .rd_addr(addr_q), .rd_data(rd_data)
    );

    nbl_outdrv #(.DW(DW)) u_outdrv (
        .op(op_q), .oe_n(oe_n), .sleep(sleep), .rd_data(rd_data),
        .q(q), .q_drive(q_drive)
    );
endmodule

// File: rtl/nbl_sram_chk.sv
// Protocol checker for nbl_sram, attached to the top by bind.
// Watches the ports and the registered operation and address.
module nbl_sram_chk
    import nbl_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs1_n,
    input logic          cs2,
    input logic          cs3_n,
    input logic          adv_ld,
    input logic          cke_n,
    input logic          sleep,
    input logic          oe_n,
    input logic          q_drive,
    input nbl_op_e       op_q,
    input logic [AW-1:0] addr_q
);
    // R7
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> !q_drive);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drive);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !q_drive);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n || sleep) |=> ($stable(addr_q) && $stable(op_q)));

    // R4
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !sleep && adv_ld) |=>
            (addr_q[AW-1:2] == $past(addr_q[AW-1:2])) &&
            (addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)) &&
            $stable(op_q));

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !sleep && !adv_ld && !(!cs1_n && cs2 && !cs3_n))
            |=> (op_q == OP_IDLE));
endmodule

bind nbl_sram nbl_sram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv_ld(adv_ld), .cke_n(cke_n), .sleep(sleep), .oe_n(oe_n),
    .q_drive(q_drive), .op_q(op_q), .addr_q(addr_q)
);

// File: tb/tb_nbl_sram.sv
// Directed bench for nbl_sram: one task per scenario, each checking itself.
module tb_nbl_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int DW = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          adv_ld = 1'b0, we_n = 1'b1, cke_n = 1'b0, sleep = 1'b0;
    logic          oe_n = 1'b0;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic          q_drive;

    int n_checks = 0;
    int n_fail   = 0;

    nbl_sram #(.AW(AW), .NB(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .cke_n(cke_n),
        .sleep(sleep), .oe_n(oe_n), .addr(addr), .din(din),
        .q(q), .q_drive(q_drive)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_read(input logic [AW-1:0] a);
        cs1_n = 0; cs2 = 1; cs3_n = 0; adv_ld = 0; we_n = 1; addr = a;
        tick();
    endtask

    task automatic load_write(input logic [AW-1:0] a, input logic [NB-1:0] bw);
        cs1_n = 0; cs2 = 1; cs3_n = 0; adv_ld = 0; we_n = 0; bw_n = bw; addr = a;
        tick();
    endtask

    task automatic adv(input logic [DW-1:0] d);
        adv_ld = 1; din = d;
        tick();
    endtask

    task automatic desel(input logic [DW-1:0] d);
        cs1_n = 1; adv_ld = 0; din = d;
        tick();
        cs1_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; oe_n = 0;
        tick(); tick();
        rst_n = 1;
        check("R1 no drive after reset", DW'(q_drive), DW'(0));
    endtask

    task automatic t_write_burst_wrap();
        oe_n = 0;
        load_write(4'd4, 2'b00);
        adv(16'h1000);
        check("R7 no drive during write", DW'(q_drive), DW'(0));
        adv(16'h2001);
        adv(16'h3002);
        adv(16'h4003);
        desel(16'h1000);
        load_read(4'd6);
        check("R3 read loaded word", q, 16'h3002);
        check("R3 drive on read", DW'(q_drive), DW'(1));
        cs1_n = 1; we_n = 0;
        adv(16'h0);
        check("R4 next beat, selects ignored", q, 16'h4003);
        adv(16'h0);
        check("R4 wrap within group", q, 16'h1000);
        adv(16'h0);
        check("R4 after wrap", q, 16'h2001);
        cs1_n = 0; we_n = 1;
    endtask

    task automatic t_partial_and_abort();
        load_write(4'd9, 2'b00);
        desel(16'h1111);
        load_write(4'd9, 2'b10);
        desel(16'hABCD);
        load_read(4'd9);
        check("R5 byte 0 only written", q, 16'h11CD);
        load_write(4'd9, 2'b11);
        adv(16'hFFFF);
        desel(16'hFFFF);
        load_read(4'd9);
        check("R6 abort keeps word", q, 16'h11CD);
    endtask

    task automatic t_deselect();
        for (int c = 0; c < 3; c++) begin
            cs1_n = (c == 0); cs2 = (c != 1); cs3_n = (c == 2);
            adv_ld = 0; we_n = 0; bw_n = 2'b00; addr = 4'd9;
            tick();
            check("R2 deselect drives nothing", DW'(q_drive), DW'(0));
            adv_ld = 1; cs1_n = 0; cs2 = 1; cs3_n = 0; din = 16'hDEAD;
            tick();
            check("R11 continued deselect", DW'(q_drive), DW'(0));
            desel(16'hDEAD);
        end
        we_n = 1;
        load_read(4'd9);
        check("R2 deselect wrote nothing", q, 16'h11CD);
    endtask

    task automatic t_oe_async();
        load_read(4'd9);
        oe_n = 1; #1;
        check("R8 oe off without edge", DW'(q_drive), DW'(0));
        oe_n = 0; #1;
        check("R8 oe on without edge", q, 16'h11CD);
    endtask

    task automatic t_stall();
        load_read(4'd4);
        cke_n = 1;
        adv(16'h0);
        check("R9 stalled read holds address", q, 16'h1000);
        load_write(4'd10, 2'b00);
        cke_n = 0;
        load_write(4'd10, 2'b00);
        cke_n = 1;
        adv(16'h5555);
        cke_n = 0;
        adv(16'h6666);
        desel(16'h7777);
        load_read(4'd10);
        check("R9 stalled edge did not write", q, 16'h6666);
        adv(16'h0);
        check("R9 burst resumed after stall", q, 16'h7777);
    endtask

    task automatic t_sleep();
        load_read(4'd4);
        sleep = 1; #1;
        check("R10 sleep releases bus", DW'(q_drive), DW'(0));
        adv(16'h0);
        adv(16'h0);
        sleep = 0; #1;
        check("R10 edges ignored in sleep", q, 16'h1000);
    endtask

    task automatic t_dummy_read();
        oe_n = 1;
        load_read(4'd4);
        check("R12 dummy read silent", DW'(q_drive), DW'(0));
        adv(16'h0);
        oe_n = 0; #1;
        check("R12 dummy read advanced", q, 16'h2001);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_write_burst_wrap();
        t_partial_and_abort();
        t_deselect();
        t_oe_async();
        t_stall();
        t_sleep();
        t_dummy_read();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule